// File: doc/BRIEF.md
# Compare-Match General-Purpose Timer

This block is a peripheral timer with a free-running up-counter. The counter advances on a selected count tick, and the block raises an interrupt when the counter steps onto a value that software has programmed. Software reaches it through a simple word-addressed register bus. Every write takes one cycle. Read data comes back from a register one cycle after the request.

The count tick comes from one of three tick-enable inputs: a bus-clock tick, a peripheral-clock tick and a crystal tick. A 3-bit code in the control register picks the tick. The crystal tick can first pass through its own small divider. The selected tick then goes through a main prescaler before it reaches the counter. To schedule an event, software reads the counter, adds a delta and writes the sum into the compare register. Software clears the match flag by writing one to it. An enable register gates the flag onto the interrupt line.

A wait-mode input freezes counting unless a control bit allows the timer to run during wait.

Top module: `cmp_timer`

## Requirements
- R1: The registers sit at these byte offsets: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24 (read-only). All of them are zero after reset. Unused bits read as zero, so writing all ones to control reads back 0x7C9 and to the prescaler reads back 0xFFFF. Any other offset reads as zero.
- R2: Control bit 0 enables the timer. While it is clear, the counter and both prescalers are held at zero and no count tick is taken.
- R3: Control bits 8:6 choose the count tick: code 1 is the bus tick, code 2 the peripheral tick and code 5 the crystal tick. Every other code stops counting.
- R4: Prescaler bits 11:0 hold P. The counter rises by exactly one for every P+1 selected ticks.
- R5: When control bit 10 is set, the crystal tick is divided by N+1, where N is prescaler bits 15:12, before it reaches the main prescaler. When bit 10 is clear, the crystal tick passes undivided.
- R6: While the wait_mode input is high and control bit 3 is clear, the counter holds its value. With bit 3 set, it keeps counting.
- R7: The counter keeps counting through a compare match and wraps from its maximum value to zero. Control bit 9 (free-run) is stored and read back.
- R8: Status bit 0 is set when the counter steps onto the compare value. A compare value already behind the counter matches only after the counter wraps around to it.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R10: If a match and a clearing write fall in the same cycle, the status bit ends up set.
- R11: irq equals status bit 0 AND interrupt-enable bit 0, registered one cycle later. Clearing the enable drops irq and leaves the status bit as it was.
- R12: Read data is registered. It appears on bus_rdata in the cycle after bus_rd and is zero when no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tick_bus | input | 1 | Bus-clock tick enable |
| tick_per | input | 1 | Peripheral-clock tick enable |
| tick_xtal | input | 1 | Crystal tick enable |
| wait_mode | input | 1 | Wait-mode request |
| irq | output | 1 | Compare-match interrupt |

## Verification
A counter step that lands on the compare value can fall in the same cycle as a software write of one to the status bit. The bench provokes this by first bringing the counter to one below the compare value. It then drives the bus tick and the clearing write on the same edge. The status bit read afterwards must be one: the set wins over the clear. The checker also watches the opposite case, where a clearing write with no match in that cycle must leave the bit zero.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int REG_W = 32;

  // word indexes (byte offset / 4)
  localparam int WIX_CTRL = 0;
  localparam int WIX_PRE  = 1;
  localparam int WIX_STAT = 2;
  localparam int WIX_IE   = 3;
  localparam int WIX_CMP  = 4;
  localparam int WIX_CNT  = 9;

  // control field positions
  localparam int CTL_EN     = 0;
  localparam int CTL_WAIT   = 3;
  localparam int CTL_SRC_LO = 6;
  localparam int CTL_SRC_W  = 3;
  localparam int CTL_FREE   = 9;
  localparam int CTL_XEN    = 10;

  localparam logic [CTL_SRC_W-1:0] SRC_BUS  = 3'd1;
  localparam logic [CTL_SRC_W-1:0] SRC_PER  = 3'd2;
  localparam logic [CTL_SRC_W-1:0] SRC_XTAL = 3'd5;

  typedef struct packed {
    logic                 xen;
    logic                 free;
    logic [CTL_SRC_W-1:0] src;
    logic                 waiten;
    logic                 en;
  } ctrl_t;
endpackage

// File: rtl/cmp_timer_div.sv
module cmp_timer_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] div_val,
  output logic         tick_out
);
  logic [W-1:0] acc_q;
  logic         hit;

  assign hit      = tick_in && (acc_q >= div_val);
  assign tick_out = hit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (tick_in) begin
      acc_q <= hit ? '0 : acc_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_tick_src.sv
module cmp_timer_tick_src
  import cmp_timer_pkg::*;
#(
  parameter int PRE_W  = 12,
  parameter int XDIV_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 run,
  input  logic [CTL_SRC_W-1:0] src,
  input  logic                 xen,
  input  logic [XDIV_W-1:0]    xdiv,
  input  logic [PRE_W-1:0]     pdiv,
  input  logic                 tick_bus,
  input  logic                 tick_per,
  input  logic                 tick_xtal,
  output logic                 step
);
  logic xt_div_out;
  logic xt_tick;
  logic sel_tick;

  cmp_timer_div #(.W(XDIV_W)) u_xdiv (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr || !xen),
    .tick_in  (tick_xtal && run),
    .div_val  (xdiv),
    .tick_out (xt_div_out)
  );

  assign xt_tick = xen ? xt_div_out : tick_xtal;

  always_comb begin
    case (src)
      SRC_BUS:  sel_tick = tick_bus;
      SRC_PER:  sel_tick = tick_per;
      SRC_XTAL: sel_tick = xt_tick;
      default:  sel_tick = 1'b0;
    endcase
  end

  cmp_timer_div #(.W(PRE_W)) u_pdiv (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .tick_in  (sel_tick && run),
    .div_val  (pdiv),
    .tick_out (step)
  );
endmodule

// File: rtl/cmp_timer_cnt.sv
module cmp_timer_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign match   = step && (cnt_inc == cmp_val);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int XDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tick_bus,
  input  logic              tick_per,
  input  logic              tick_xtal,
  input  logic              wait_mode,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  ctrl_t             ctrl_q;
  logic [PRE_W-1:0]  pdiv_q;
  logic [XDIV_W-1:0] xdiv_q;
  logic              stat_q;
  logic              ie_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              irq_q;
  logic [REG_W-1:0]  rdata_q;
  logic [REG_W-1:0]  rd_mux;

  logic [WORD_W-1:0] word;
  logic              run;
  logic              halt;
  logic              step;
  logic              match;
  logic              stat_clr;
  logic [CNT_W-1:0]  cnt;

  assign word     = bus_addr[ADDR_W-1:2];
  assign halt     = !ctrl_q.en;
  assign run      = ctrl_q.en && (!wait_mode || ctrl_q.waiten);
  assign stat_clr = bus_wr && (word == WORD_W'(WIX_STAT)) && bus_wdata[0];

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pdiv_q <= '0;
      xdiv_q <= '0;
      ie_q   <= 1'b0;
      cmp_q  <= '0;
    end else if (bus_wr) begin
      case (word)
        WORD_W'(WIX_CTRL): begin
          ctrl_q.en     <= bus_wdata[CTL_EN];
          ctrl_q.waiten <= bus_wdata[CTL_WAIT];
          ctrl_q.src    <= bus_wdata[CTL_SRC_LO +: CTL_SRC_W];
          ctrl_q.free   <= bus_wdata[CTL_FREE];
          ctrl_q.xen    <= bus_wdata[CTL_XEN];
        end
        WORD_W'(WIX_PRE): begin
          pdiv_q <= bus_wdata[PRE_W-1:0];
          xdiv_q <= bus_wdata[PRE_W +: XDIV_W];
        end
        WORD_W'(WIX_IE):  ie_q  <= bus_wdata[0];
        WORD_W'(WIX_CMP): cmp_q <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // status: a match in the same cycle beats the clearing write
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
    end else if (match) begin
      stat_q <= 1'b1;
    end else if (stat_clr) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= stat_q && ie_q;
  end

  cmp_timer_tick_src #(.PRE_W(PRE_W), .XDIV_W(XDIV_W)) u_src (
    .clk       (clk),
    .rst       (rst),
    .clr       (halt),
    .run       (run),
    .src       (ctrl_q.src),
    .xen       (ctrl_q.xen),
    .xdiv      (xdiv_q),
    .pdiv      (pdiv_q),
    .tick_bus  (tick_bus),
    .tick_per  (tick_per),
    .tick_xtal (tick_xtal),
    .step      (step)
  );

  cmp_timer_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (halt),
    .step    (step),
    .cmp_val (cmp_q),
    .cnt     (cnt),
    .match   (match)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    case (word)
      WORD_W'(WIX_CTRL): begin
        rd_mux[CTL_EN]                  = ctrl_q.en;
        rd_mux[CTL_WAIT]                = ctrl_q.waiten;
        rd_mux[CTL_SRC_LO +: CTL_SRC_W] = ctrl_q.src;
        rd_mux[CTL_FREE]                = ctrl_q.free;
        rd_mux[CTL_XEN]                 = ctrl_q.xen;
      end
      WORD_W'(WIX_PRE): begin
        rd_mux[PRE_W-1:0]       = pdiv_q;
        rd_mux[PRE_W +: XDIV_W] = xdiv_q;
      end
      WORD_W'(WIX_STAT): rd_mux[0] = stat_q;
      WORD_W'(WIX_IE):   rd_mux[0] = ie_q;
      WORD_W'(WIX_CMP):  rd_mux = REG_W'(cmp_q);
      WORD_W'(WIX_CNT):  rd_mux = REG_W'(cnt);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             waiten,
  input logic             wait_mode,
  input logic [CNT_W-1:0] cnt,
  input logic             match,
  input logic             stat_clr,
  input logic             stat,
  input logic             ie,
  input logic             irq
);
  p_off_holds_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

  p_step_by_one_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

  p_wait_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (en && wait_mode && !waiten) |=> $stable(cnt));

  p_match_sets_r8: assert property (@(posedge clk) disable iff (rst)
    match |=> stat);

  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !match) |=> !stat);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && match) |=> stat);

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    irq == $past(stat && ie));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (ctrl_q.en),
  .waiten    (ctrl_q.waiten),
  .wait_mode (wait_mode),
  .cnt       (cnt),
  .match     (match),
  .stat_clr  (stat_clr),
  .stat      (stat_q),
  .ie        (ie_q),
  .irq       (irq)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  localparam int CW = 8;
  localparam int NV = 9;
  localparam int PATTERN_CYC = 48;

  // {src[2:0], xen, xdiv[3:0], pdiv[11:0], expected[7:0]}
  localparam logic [27:0] VEC [NV] = '{
    {3'd1, 1'b0, 4'd0, 12'd0,  8'd48},
    {3'd2, 1'b0, 4'd0, 12'd0,  8'd24},
    {3'd1, 1'b0, 4'd0, 12'd2,  8'd16},
    {3'd2, 1'b0, 4'd0, 12'd3,  8'd6},
    {3'd5, 1'b0, 4'd0, 12'd0,  8'd48},
    {3'd5, 1'b1, 4'd7, 12'd0,  8'd6},
    {3'd5, 1'b1, 4'd1, 12'd2,  8'd8},
    {3'd3, 1'b0, 4'd0, 12'd0,  8'd0},
    {3'd1, 1'b0, 4'd0, 12'd47, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_bus = 1'b0;
  logic        tick_per = 1'b0;
  logic        tick_xtal = 1'b0;
  logic        wait_mode = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmp_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_bus(tick_bus), .tick_per(tick_per), .tick_xtal(tick_xtal),
    .wait_mode(wait_mode), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_bus = 1'b1;
    end
    @(negedge clk);
    tick_bus = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(6'h00, d); check("R1 reset ctrl", d, 0);
    rd(6'h04, d); check("R1 reset pre", d, 0);
    rd(6'h08, d); check("R1 reset stat", d, 0);
    rd(6'h0C, d); check("R1 reset ie", d, 0);
    rd(6'h10, d); check("R1 reset cmp", d, 0);
    rd(6'h24, d); check("R1 reset cnt", d, 0);
    check("R11 reset irq", {31'd0, irq}, 0);

    // vector table: bus every cycle, peripheral every other cycle, crystal every cycle
    wr(6'h10, 32'hFF);
    for (int v = 0; v < NV; v++) begin
      wr(6'h00, 0);
      wr(6'h04, {16'd0, VEC[v][23:20], VEC[v][19:8]});
      wr(6'h00, (32'(VEC[v][24]) << 10) | (32'(VEC[v][27:25]) << 6) | 32'd1);
      for (int i = 0; i < PATTERN_CYC; i++) begin
        @(negedge clk);
        tick_bus = 1'b1; tick_per = (i % 2 == 0); tick_xtal = 1'b1;
      end
      @(negedge clk);
      tick_bus = 1'b0; tick_per = 1'b0; tick_xtal = 1'b0;
      rd(6'h24, d);
      check($sformatf("R3/R4/R5 vector %0d count", v), d, {24'd0, VEC[v][7:0]});
    end

    // compare match
    wr(6'h00, 0); wr(6'h04, 0); wr(6'h08, 1);
    wr(6'h10, 5); wr(6'h0C, 1); wr(6'h00, 32'h41);
    pulses(4);
    rd(6'h08, d); check("R8 no match before compare", d, 0);
    pulses(1);
    rd(6'h08, d); check("R8 match sets status", d, 1);
    check("R11 irq with enable", {31'd0, irq}, 1);
    pulses(2);
    rd(6'h24, d); check("R7 counts past match", d, 7);
    wr(6'h08, 0);
    rd(6'h08, d); check("R9 write zero keeps status", d, 1);
    wr(6'h08, 1);
    rd(6'h08, d); check("R9 write one clears status", d, 0);
    check("R11 irq drops after clear", {31'd0, irq}, 0);

    // enable gating
    wr(6'h0C, 0); wr(6'h10, 8);
    pulses(1);
    rd(6'h08, d); check("R11 status set with enable off", d, 1);
    check("R11 irq masked", {31'd0, irq}, 0);
    wr(6'h0C, 1);
    @(negedge clk);
    check("R11 irq after enable", {31'd0, irq}, 1);
    wr(6'h08, 1);

    // same-cycle set and clear (counter 8 -> 9, then 9 -> 10 with write)
    wr(6'h10, 10);
    pulses(1);
    @(negedge clk);
    bus_addr = 6'h08; bus_wdata = 1; bus_wr = 1'b1; tick_bus = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_bus = 1'b0;
    rd(6'h08, d); check("R10 set wins over clear", d, 1);
    wr(6'h08, 1);

    // compare behind counter, wrap
    wr(6'h10, 4);
    pulses(100);
    rd(6'h08, d); check("R8 behind compare no match", d, 0);
    pulses(146);
    rd(6'h24, d); check("R7 wrap to zero", d, 0);
    rd(6'h08, d); check("R8 still no match at wrap", d, 0);
    pulses(4);
    rd(6'h08, d); check("R8 match after wrap", d, 1);
    wr(6'h08, 1);

    // wait mode
    wait_mode = 1'b1;
    pulses(5);
    rd(6'h24, d); check("R6 frozen in wait", d, 4);
    wr(6'h00, 32'h49);
    pulses(5);
    rd(6'h24, d); check("R6 counts with wait enable", d, 9);
    wait_mode = 1'b0;

    // disable
    wr(6'h00, 32'h40);
    pulses(3);
    rd(6'h24, d); check("R2 disabled counter zero", d, 0);

    // masks and unmapped
    wr(6'h00, 32'hFFFFFFFF);
    rd(6'h00, d); check("R1 ctrl mask", d, 32'h7C9);
    check("R7 free-run bit stored", {31'd0, d[9]}, 1);
    wr(6'h04, 32'hFFFFFFFF);
    rd(6'h04, d); check("R1 pre mask", d, 32'hFFFF);
    wr(6'h0C, 32'hFFFFFFFF);
    rd(6'h0C, d); check("R1 ie mask", d, 1);
    wr(6'h10, 32'hFFFFFFFF);
    rd(6'h10, d); check("R1 cmp width", d, 32'hFF);
    rd(6'h14, d); check("R1 unmapped 0x14", d, 0);
    rd(6'h3C, d); check("R1 unmapped 0x3C", d, 0);
    @(negedge clk);
    check("R12 rdata zero without read", bus_rdata, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule